// File: doc/BRIEF.md
# Monochrome glyph expansion engine

The engine turns one-bit-per-pixel glyph rows into 32-bit colour pixel writes for a frame buffer. Software programs a glyph width, a packed start position, a packed per-row position step, a foreground/background colour pair and a background mode. It then pushes one 32-bit word per glyph row. The engine walks the word from its most significant bit and emits one pixel write per clock at consecutive X coordinates. A 1 bit is painted with the foreground colour. A 0 bit is painted with the background colour, or skipped when the background is transparent.

When the row is complete, the engine adds the step to the position register so that the next row lands where software wants it. The Y and X halves are added separately. Glyphs wider than 32 pixels are sent by software as separate strips. The row input stalls while a row is still being expanded.

Top module: `glyph_expand`

## Requirements
- R1: After reset `row_ready` is 1 and `px_we` is 0. The configuration defaults are: width 32, position Y=0/X=0, step Y=1/X=0, both colours 0, opaque background.
- R2: A row accepted at position (Y,X) produces its pixels on consecutive cycles, starting the cycle after acceptance. Pixel i comes from data bit 31-i and is written at (Y, X+i).
- R3: With an opaque background, every pixel of the row is written. A 1 bit gets the foreground colour and a 0 bit gets the background colour.
- R4: The mode field is `cfg_wdata[1:0]` written with select 4. Code 2'b11 selects a transparent background, where 0 bits produce no write and use up their cycle. Every other code, including 2'b10, gives an opaque background.
- R5: The width is `cfg_wdata[5:0]` written with select 0. Only the leftmost W bits of a row are expanded. A value of 0 or above 32 acts as 32.
- R6: `row_ready` falls in the cycle after a row is accepted and stays low for exactly W cycles. It is low whenever a pixel is written.
- R7: When a row ends, the position becomes position + step. Y is in bits 31:16 and X is in bits 15:0. Each half wraps modulo 2^16 and there is no carry between the halves. Position is written with select 1 and the step with select 2.
- R8: A position write in the last pixel cycle of a row wins over the end-of-row step. A position write earlier in the row is itself stepped when the row ends. The row in flight keeps its original base.
- R9: Select 3 loads both colours at once: foreground from `cfg_wdata[63:32]` and background from `cfg_wdata[31:0]`.
- R10: Writes with select codes 5, 6 or 7 change no setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Setting select: 0 width, 1 position, 2 step, 3 colours, 4 mode |
| cfg_wdata | input | 64 | Configuration write data |
| row_valid | input | 1 | A glyph row word is offered |
| row_data | input | 32 | Glyph row, leftmost pixel in bit 31 |
| row_ready | output | 1 | Engine can take a row this cycle |
| px_we | output | 1 | Pixel write strobe |
| px_x | output | 16 | Pixel X coordinate |
| px_y | output | 16 | Pixel Y coordinate |
| px_color | output | 32 | Pixel colour |

## Verification
The end-of-row position step and a software write to the position register can land in the same clock edge. The bench provokes this by timing a position write into the cycle that carries the last pixel of a row, and again into an earlier pixel cycle. It judges the outcome from the coordinates of the following row. That row must start at the written value in the first case and at the written value plus the step in the second. The scoreboard also confirms that the row in flight keeps the base it started with.

// File: rtl/glx_pkg.sv
package glx_pkg;
    parameter int ROW_BITS = 32;
    parameter int COORD_W  = 16;
    parameter int PIX_W    = 32;
    localparam int CNT_W   = $clog2(ROW_BITS) + 1;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_WIDTH = 3'd0,
        SEL_POS   = 3'd1,
        SEL_STEP  = 3'd2,
        SEL_COLOR = 3'd3,
        SEL_MODE  = 3'd4
    } sel_e;

    localparam logic [1:0] BG_OPAQUE = 2'b10;
    localparam logic [1:0] BG_CLEAR  = 2'b11;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } xy_t;
endpackage

// File: rtl/glx_regs.sv
module glx_regs
    import glx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [2*PIX_W-1:0]   cfg_wdata,
    input  logic                 row_done,
    output logic [CNT_W-1:0]     eff_width,
    output xy_t                  pos,
    output logic [PIX_W-1:0]     fg,
    output logic [PIX_W-1:0]     bg,
    output logic                 transp
);
    typedef struct packed {
        logic [CNT_W-1:0] width;
        xy_t              pos;
        xy_t              step;
        logic [PIX_W-1:0] fg;
        logic [PIX_W-1:0] bg;
        logic [1:0]       mode;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        // end-of-row step first, so a software write in the same cycle wins
        if (row_done) begin
            regs_d.pos.x = regs_q.pos.x + regs_q.step.x;
            regs_d.pos.y = regs_q.pos.y + regs_q.step.y;
        end
        if (cfg_we) begin
            case (sel_e'(cfg_sel))
                SEL_WIDTH: regs_d.width = cfg_wdata[CNT_W-1:0];
                SEL_POS:   regs_d.pos   = cfg_wdata[2*COORD_W-1:0];
                SEL_STEP:  regs_d.step  = cfg_wdata[2*COORD_W-1:0];
                SEL_COLOR: begin
                    regs_d.fg = cfg_wdata[2*PIX_W-1:PIX_W];
                    regs_d.bg = cfg_wdata[PIX_W-1:0];
                end
                SEL_MODE:  regs_d.mode  = cfg_wdata[1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.width <= CNT_W'(ROW_BITS);
            regs_q.pos   <= '0;
            regs_q.step  <= '{y: COORD_W'(1), x: '0};
            regs_q.fg    <= '0;
            regs_q.bg    <= '0;
            regs_q.mode  <= BG_OPAQUE;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign eff_width = (regs_q.width == '0 || regs_q.width > CNT_W'(ROW_BITS))
                       ? CNT_W'(ROW_BITS) : regs_q.width;
    assign pos    = regs_q.pos;
    assign fg     = regs_q.fg;
    assign bg     = regs_q.bg;
    assign transp = (regs_q.mode == BG_CLEAR);
endmodule

// File: rtl/glx_expand.sv
module glx_expand
    import glx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 row_valid,
    input  logic [ROW_BITS-1:0]  row_data,
    input  logic [CNT_W-1:0]     eff_width,
    input  xy_t                  pos,
    input  logic [PIX_W-1:0]     fg,
    input  logic [PIX_W-1:0]     bg,
    input  logic                 transp,
    output logic                 row_ready,
    output logic                 row_done,
    output logic                 px_we,
    output logic [COORD_W-1:0]   px_x,
    output logic [COORD_W-1:0]   px_y,
    output logic [PIX_W-1:0]     px_color
);
    typedef struct packed {
        logic                busy;
        logic [ROW_BITS-1:0] bits;
        logic [CNT_W-1:0]    idx;
        xy_t                 base;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_px;
    logic cur_bit;

    assign cur_bit = eng_q.bits[ROW_BITS-1];
    assign last_px = eng_q.busy && (eng_q.idx == eff_width - CNT_W'(1));

    always_comb begin
        eng_d = eng_q;
        if (eng_q.busy) begin
            eng_d.bits = {eng_q.bits[ROW_BITS-2:0], 1'b0};
            eng_d.idx  = eng_q.idx + CNT_W'(1);
            if (last_px) begin
                eng_d.busy = 1'b0;
            end
        end else if (row_valid) begin
            eng_d.busy = 1'b1;
            eng_d.bits = row_data;
            eng_d.idx  = '0;
            eng_d.base = pos;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign row_ready = !eng_q.busy;
    assign row_done  = last_px;
    assign px_we     = eng_q.busy && (cur_bit || !transp);
    assign px_x      = eng_q.base.x + COORD_W'(eng_q.idx);
    assign px_y      = eng_q.base.y;
    assign px_color  = cur_bit ? fg : bg;
endmodule

// File: rtl/glyph_expand.sv
module glyph_expand
    import glx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [SEL_W-1:0]     cfg_sel,
    input  logic [2*PIX_W-1:0]   cfg_wdata,
    input  logic                 row_valid,
    input  logic [ROW_BITS-1:0]  row_data,
    output logic                 row_ready,
    output logic                 px_we,
    output logic [COORD_W-1:0]   px_x,
    output logic [COORD_W-1:0]   px_y,
    output logic [PIX_W-1:0]     px_color
);
    logic [CNT_W-1:0] eff_width;
    xy_t              cur_pos;
    logic [PIX_W-1:0] cfg_fg;
    logic [PIX_W-1:0] cfg_bg;
    logic             cfg_transp;
    logic             row_done;

    glx_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .row_done  (row_done),
        .eff_width (eff_width),
        .pos       (cur_pos),
        .fg        (cfg_fg),
        .bg        (cfg_bg),
        .transp    (cfg_transp)
    );

    glx_expand u_expand (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .row_data  (row_data),
        .eff_width (eff_width),
        .pos       (cur_pos),
        .fg        (cfg_fg),
        .bg        (cfg_bg),
        .transp    (cfg_transp),
        .row_ready (row_ready),
        .row_done  (row_done),
        .px_we     (px_we),
        .px_x      (px_x),
        .px_y      (px_y),
        .px_color  (px_color)
    );
endmodule

// File: rtl/glx_chk.sv
module glx_chk
    import glx_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               row_valid,
    input logic               row_ready,
    input logic               row_done,
    input logic               px_we,
    input logic [COORD_W-1:0] px_x,
    input logic [COORD_W-1:0] px_y,
    input logic [PIX_W-1:0]   px_color,
    input logic [PIX_W-1:0]   fg,
    input logic               transp
);
    assert_px_only_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        px_we |-> !row_ready);

    assert_accept_stalls_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (row_valid && row_ready) |=> !row_ready);

    assert_done_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |=> row_ready);

    assert_done_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        row_done |-> !row_ready);

    assert_x_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_ready && !row_done) |=> (px_x == $past(px_x) + COORD_W'(1) && $stable(px_y)));

    assert_clear_only_fg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (px_we && transp) |-> (px_color == fg));
endmodule

bind glyph_expand glx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_valid (row_valid),
    .row_ready (row_ready),
    .row_done  (row_done),
    .px_we     (px_we),
    .px_x      (px_x),
    .px_y      (px_y),
    .px_color  (px_color),
    .fg        (cfg_fg),
    .transp    (cfg_transp)
);

// File: tb/glyph_expand_bench.sv
`timescale 1ns/1ps
module glyph_expand_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [63:0] cfg_wdata = '0;
    logic        row_valid = 1'b0;
    logic [31:0] row_data = '0;
    logic        row_ready;
    logic        px_we;
    logic [15:0] px_x;
    logic [15:0] px_y;
    logic [31:0] px_color;

    always #5 clk = ~clk;

    glyph_expand u_glyph_expand (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .row_valid(row_valid), .row_data(row_data),
        .row_ready(row_ready), .px_we(px_we), .px_x(px_x), .px_y(px_y),
        .px_color(px_color)
    );

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
        logic [31:0] c;
    } pix_t;

    pix_t  exp_q[$];
    int    checks = 0;
    int    bad = 0;
    string cur_req = "R1";

    int          m_w = 32;
    logic [15:0] m_px = 0, m_py = 0, m_sx = 0, m_sy = 1;
    logic [31:0] m_fg = 0, m_bg = 0;
    logic        m_clear = 0;

    task automatic check(input string req, input logic ok, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // monitor: pops and compares every pixel write
    always @(negedge clk) begin
        if (rst_n && px_we) begin
            if (exp_q.size() == 0) begin
                check(cur_req, 1'b0, {px_x, px_y, px_color}, 64'h0);
            end else begin
                pix_t e;
                e = exp_q.pop_front();
                check(cur_req, {px_x, px_y, px_color} == e, {px_x, px_y, px_color}, e);
            end
        end
    end

    task automatic cfg_write(input logic [2:0] sel, input logic [63:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            3'd0: m_w = (data[5:0] == 0 || data[5:0] > 32) ? 32 : int'(data[5:0]);
            3'd1: begin m_py = data[31:16]; m_px = data[15:0]; end
            3'd2: begin m_sy = data[31:16]; m_sx = data[15:0]; end
            3'd3: begin m_fg = data[63:32]; m_bg = data[31:0]; end
            3'd4: m_clear = (data[1:0] == 2'b11);
            default: ;
        endcase
    endtask

    task automatic expect_row(input logic [31:0] data);
        for (int i = 0; i < m_w; i++) begin
            pix_t p;
            logic b;
            b = data[31-i];
            if (b || !m_clear) begin
                p.x = m_px + 16'(i);
                p.y = m_py;
                p.c = b ? m_fg : m_bg;
                exp_q.push_back(p);
            end
        end
        m_px = m_px + m_sx;
        m_py = m_py + m_sy;
    endtask

    task automatic push_row(input logic [31:0] data);
        int n;
        @(negedge clk);
        while (!row_ready) @(negedge clk);
        expect_row(data);
        row_valid = 1'b1; row_data = data;
        @(negedge clk);
        row_valid = 1'b0;
        n = 0;
        while (!row_ready) begin
            n++;
            @(negedge clk);
        end
        check("R6 stall length", n == m_w, 64'(n), 64'(m_w));
        check("R5 pixel count", exp_q.size() == 0, 64'(exp_q.size()), 64'h0);
    endtask

    // position write timed into pixel cycle k of a row
    task automatic collide(input logic [31:0] data, input int k, input logic [31:0] newpos);
        int w;
        w = m_w;
        @(negedge clk);
        while (!row_ready) @(negedge clk);
        expect_row(data);
        row_valid = 1'b1; row_data = data;
        @(negedge clk);
        row_valid = 1'b0;
        for (int i = 1; i < k; i++) @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 3'd1; cfg_wdata = {32'h0, newpos};
        @(negedge clk);
        cfg_we = 1'b0;
        m_py = newpos[31:16]; m_px = newpos[15:0];
        if (k != w) begin
            m_px = m_px + m_sx;
            m_py = m_py + m_sy;
        end
        while (!row_ready) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cur_req = "R1";
        check("R1 ready in reset", row_ready == 1'b1, 64'(row_ready), 64'h1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", row_ready == 1'b1, 64'(row_ready), 64'h1);
        check("R1 no write after reset", px_we == 1'b0, 64'(px_we), 64'h0);
        // defaults: 32 wide, origin, step down one line, colours 0
        push_row(32'hA5A5_0F0F);
        push_row(32'h0000_0001);

        cur_req = "R9";
        cfg_write(3'd3, {32'h00FF_8800, 32'h0011_2233});
        cur_req = "R3";
        cfg_write(3'd1, {32'h0, 16'd10, 16'd100});
        push_row(32'h8000_0001);
        push_row(32'hF0F0_1234);
        cur_req = "R2";
        push_row(32'h1234_5678);

        cur_req = "R5";
        cfg_write(3'd0, 64'd5);
        push_row(32'hA7FF_FFFF);
        cfg_write(3'd0, 64'd1);
        push_row(32'h7FFF_FFFF);
        cfg_write(3'd0, 64'd0);
        push_row(32'hC000_0003);
        cfg_write(3'd0, 64'd40);
        push_row(32'h3C3C_3C3C);
        cfg_write(3'd0, 64'd32);

        cur_req = "R4";
        cfg_write(3'd4, 64'h3);
        push_row(32'h0000_0000);
        push_row(32'h8000_0001);
        push_row(32'h5555_5555);
        cfg_write(3'd4, 64'h1);
        push_row(32'h5555_5555);
        cfg_write(3'd4, 64'h2);

        cur_req = "R7";
        cfg_write(3'd0, 64'd8);
        cfg_write(3'd2, {32'h0, 16'h0003, 16'hFFFE});
        cfg_write(3'd1, {32'h0, 16'hFFFF, 16'h0005});
        push_row(32'hF000_0000);
        push_row(32'h0F00_0000);
        push_row(32'hAA00_0000);

        cur_req = "R8";
        cfg_write(3'd2, {32'h0, 16'h0001, 16'h0000});
        collide(32'hC300_0000, 8, {16'd200, 16'd300});
        push_row(32'h8100_0000);
        collide(32'h1800_0000, 3, {16'd400, 16'd50});
        push_row(32'hFF00_0000);

        cur_req = "R10";
        cfg_write(3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        cfg_write(3'd6, 64'h0);
        cfg_write(3'd7, 64'h1234_5678_9ABC_DEF0);
        push_row(32'h9900_0000);

        @(negedge clk);
        check("R6 queue drained", exp_q.size() == 0, 64'(exp_q.size()), 64'h0);
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule